// File: doc/BRIEF.md
# Serial Display-Memory Command Interface

This block is the slave end of a four-wire serial link (chip select, write strobe, read strobe, one data line) that gives a host access to a 32 × 4-bit display memory and to the panel configuration held beside it. All four pins are oversampled by a faster system clock. A session opens when chip select goes low. The host first sends a 3-bit mode ID, and that ID selects command mode or one of the data modes.

In command mode the host sends a stream of 9-bit codes with no further IDs between them. The codes switch the system enable and the display enable, and they set the bias ratio and the common count. In the data modes the host sends a 6-bit start address and then moves 4-bit nibbles. The address advances after each nibble, and an optional read-before-write at each address shares the write session. Raising chip select ends any session at once and clears the interface sequencer. The memory image and the configuration bits go straight out to downstream panel-drive logic.

Top module: `serlcd_link`

## Requirements
- R1: After reset, `sys_en`, `lcd_on` and `bias_third` are 0, `com_sel` is 2'b00, every memory nibble is 0 and `sdata_oe` is 0.
- R2: While `cs_n` is high, WR and RD strobes change neither the memory nor the configuration. A session cut short by `cs_n` rising is discarded, and the first three bits after `cs_n` falls are always read as a new mode ID.
- R3: Bits are taken on rising edges of `wr_n`, most significant first. Mode ID 3'b100 opens command mode. In command mode every later group of 9 bits is one command, and no ID is repeated between commands. The ninth bit of each command is don't-care.
- R4: Command 0000_0001X sets `sys_en` and 0000_0000X clears it.
- R5: Command 0000_0011X sets `lcd_on` and 0000_0010X clears it.
- R6: Command 0010_abXcX sets `com_sel` = {a,b} (00: two commons, 01: three, 10: four) and sets `bias_third` = c (0: 1/2 bias, 1: 1/3 bias). When ab = 11 the whole command is ignored.
- R7: A 9-bit command matching none of the codes in R4 to R6 changes nothing.
- R8: Mode ID 3'b101 is followed by a 6-bit address, sent MSB first, whose top bit is ignored. After that, each 4 WR bits (sent LSB first) are written as one nibble at the current address. The address then steps by one and wraps from 31 to 0. Nibble n appears on `disp_ram[4n+3:4n]`.
- R9: Mode ID 3'b110 is followed by a 6-bit address. Each falling edge of `rd_n` puts the next bit of the current nibble on `sdata_out`, LSB first. The address steps, with wrap, after the fourth bit.
- R10: In a 3'b101 session, RD falling edges read the nibble at the current address LSB first, without stepping. A following 4-bit write lands at that same address and then steps it.
- R11: `sdata_oe` is high only while chip select is active and a read is under way: in a 3'b110 session, or in a 3'b101 session after an RD edge and before the next WR edge. It is low at all other times.
- R12: A mode ID other than 3'b100, 3'b101 or 3'b110 makes the rest of the session have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all link pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe; bit captured on rising edge |
| rd_n | input | 1 | Read strobe; bit launched on falling edge |
| sdata_in | input | 1 | Serial data from host |
| sdata_out | output | 1 | Serial read data to host |
| sdata_oe | output | 1 | Output enable for the shared data pad |
| sys_en | output | 1 | System enable |
| lcd_on | output | 1 | Display enable |
| bias_third | output | 1 | 1 = 1/3 bias, 0 = 1/2 bias |
| com_sel | output | 2 | Common count code (00/01/10 = 2/3/4) |
| disp_ram | output | 128 | Flat image of the 32 × 4-bit display memory |

## Verification
Each pin passes through a two-stage synchronizer, and one further register detects its edges. A strobe edge that the host makes just before clock edge k therefore takes effect at edge k+2: a configuration bit, a memory nibble or a new `sdata_out` value is visible after edge k+2. The bench holds every strobe level for at least three clocks and samples at falling clock edges four clocks after the strobe. Every result is thus read at least one cycle after it is due and before the next strobe can change it. The tests for ignored stimulus read `lcd_on`, `disp_ram` and `sdata_oe` after the ignored strobes and before any later session starts.

// File: rtl/serlcd_pkg.sv
// Shared types and constants for the serial display-memory interface.
// Assumes: mode IDs and commands arrive MSB first, data nibbles LSB first.
package serlcd_pkg;
    localparam int ID_LEN  = 3;
    localparam int CMD_LEN = 9;

    localparam logic [ID_LEN-1:0] MODE_CMD   = 3'b100;
    localparam logic [ID_LEN-1:0] MODE_READ  = 3'b110;
    localparam logic [ID_LEN-1:0] MODE_WRITE = 3'b101;

    typedef enum logic [2:0] {
        PH_ID,
        PH_CMD,
        PH_ADDR,
        PH_WRITE,
        PH_READ,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        logic       sys_en;
        logic       lcd_on;
        logic       bias_third;
        logic [1:0] com_sel;
    } cfg_t;
endpackage

// File: rtl/serlcd_sync.sv
// Multi-bit pin synchronizer: a chain of STAGES flops per bit.
// Assumes: bits are independent; reset value picks each pin's idle level.
module serlcd_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d_in;
                end
            end else begin : g_next
                // Shift one stage further from the pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/serlcd_ram.sv
// Display memory: DEPTH nibbles, one write port, one async read port,
// plus a flat image of all locations for downstream panel logic.
// Assumes: write address is always in range (AW bits, DEPTH = 2**AW).
module serlcd_ram #(
    parameter int DEPTH = 32,
    parameter int NIB   = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic [NIB-1:0]       wdata,
    input  logic [AW-1:0]        raddr,
    output logic [NIB-1:0]       rdata,
    output logic [DEPTH*NIB-1:0] image
);
    logic [NIB-1:0] mem [DEPTH];

    // Clear on reset, otherwise write one nibble when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_image
            assign image[g*NIB +: NIB] = mem[g];
        end
    endgenerate
endmodule

// File: rtl/serlcd_ctrl.sv
// Session sequencer: decodes mode ID, commands, address and data bits
// from synchronized strobe events; owns the configuration register,
// the auto-incrementing address and the serial read launch flop.
// Assumes: wr_rise / rd_fall are single-cycle pulses; cs_act is synced.
module serlcd_ctrl
    import serlcd_pkg::*;
#(
    parameter int DEPTH    = 32,
    parameter int NIB      = 4,
    parameter int ADDR_LEN = 6,
    localparam int AW      = $clog2(DEPTH),
    localparam int RW      = $clog2(NIB),
    localparam int SH_W    = (CMD_LEN > ADDR_LEN) ? CMD_LEN : ADDR_LEN,
    localparam int CW      = $clog2(SH_W + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_act,
    input  logic           wr_rise,
    input  logic           rd_fall,
    input  logic           din,
    input  logic [NIB-1:0] rd_nibble,
    output logic [AW-1:0]  addr,
    output logic           we,
    output logic [NIB-1:0] wnib,
    output cfg_t           cfg,
    output logic           dout,
    output logic           doe
);
    phase_t          phase;
    logic [SH_W-1:0] sh;
    logic [SH_W-1:0] sh_nx;
    logic [CW-1:0]   cnt;
    logic [RW-1:0]   rd_idx;
    logic [NIB-1:0]  wacc;
    logic            read_mode;
    logic            rmw_drive;
    cfg_t            cfg_nx;
    logic [7:0]      cmd;

    assign sh_nx = {sh[SH_W-2:0], din};
    assign cmd   = sh_nx[CMD_LEN-1:1];
    assign wnib  = {din, wacc[NIB-1:1]};

    // Write strobe completing the last bit of a nibble in a write session.
    assign we = cs_act && wr_rise && (phase == PH_WRITE) && (cnt == CW'(NIB-1));

    // Data pad is driven only in an active read phase.
    assign doe = cs_act && ((phase == PH_READ) || ((phase == PH_WRITE) && rmw_drive));

    // Next configuration from a complete 9-bit command; unknown codes keep it.
    always_comb begin
        cfg_nx = cfg;
        if (cmd == 8'b0000_0000)      cfg_nx.sys_en = 1'b0;
        else if (cmd == 8'b0000_0001) cfg_nx.sys_en = 1'b1;
        else if (cmd == 8'b0000_0010) cfg_nx.lcd_on = 1'b0;
        else if (cmd == 8'b0000_0011) cfg_nx.lcd_on = 1'b1;
        else if (cmd[7:4] == 4'b0010 && cmd[3:2] != 2'b11) begin
            cfg_nx.com_sel    = cmd[3:2];
            cfg_nx.bias_third = cmd[0];
        end
    end

    // Session state machine, address counter and serial launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_ID;
            sh        <= '0;
            cnt       <= '0;
            rd_idx    <= '0;
            wacc      <= '0;
            read_mode <= 1'b0;
            rmw_drive <= 1'b0;
            addr      <= '0;
            dout      <= 1'b0;
            cfg       <= '0;
        end else if (!cs_act) begin
            phase     <= PH_ID;
            sh        <= '0;
            cnt       <= '0;
            rd_idx    <= '0;
            rmw_drive <= 1'b0;
        end else begin
            case (phase)
                PH_ID: if (wr_rise) begin
                    sh <= sh_nx;
                    if (cnt == CW'(ID_LEN-1)) begin
                        cnt <= '0;
                        if (sh_nx[ID_LEN-1:0] == MODE_CMD) begin
                            phase <= PH_CMD;
                        end else if (sh_nx[ID_LEN-1:0] == MODE_READ) begin
                            phase     <= PH_ADDR;
                            read_mode <= 1'b1;
                        end else if (sh_nx[ID_LEN-1:0] == MODE_WRITE) begin
                            phase     <= PH_ADDR;
                            read_mode <= 1'b0;
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                PH_CMD: if (wr_rise) begin
                    sh <= sh_nx;
                    if (cnt == CW'(CMD_LEN-1)) begin
                        cnt <= '0;
                        cfg <= cfg_nx;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                PH_ADDR: if (wr_rise) begin
                    sh <= sh_nx;
                    if (cnt == CW'(ADDR_LEN-1)) begin
                        cnt    <= '0;
                        rd_idx <= '0;
                        addr   <= sh_nx[AW-1:0];
                        phase  <= read_mode ? PH_READ : PH_WRITE;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                PH_WRITE: begin
                    if (wr_rise) begin
                        wacc      <= wnib;
                        rmw_drive <= 1'b0;
                        if (cnt == CW'(NIB-1)) begin
                            cnt    <= '0;
                            rd_idx <= '0;
                            addr   <= addr + AW'(1);
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end else if (rd_fall) begin
                        dout      <= rd_nibble[rd_idx];
                        rd_idx    <= rd_idx + RW'(1);
                        rmw_drive <= 1'b1;
                    end
                end
                PH_READ: if (rd_fall) begin
                    dout <= rd_nibble[rd_idx];
                    if (rd_idx == RW'(NIB-1)) begin
                        rd_idx <= '0;
                        addr   <= addr + AW'(1);
                    end else begin
                        rd_idx <= rd_idx + RW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    AST_IDLE_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> $stable(cfg)); // R2
    AST_COM_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.com_sel != 2'b11); // R6
    AST_WRITE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> addr == $past(addr) + AW'(1)); // R8
    AST_READ_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && rd_fall && phase == PH_READ && rd_idx == RW'(NIB-1))
        |=> addr == $past(addr) + AW'(1)); // R9
endmodule

// File: rtl/serlcd_link.sv
// Top level: synchronizes the link pins, detects strobe edges and joins
// the sequencer to the display memory.
// Assumes: pins are asynchronous to clk and held for >= 3 clk per level.
module serlcd_link
    import serlcd_pkg::*;
#(
    parameter int DEPTH       = 32,
    parameter int NIB         = 4,
    parameter int ADDR_LEN    = 6,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 wr_n,
    input  logic                 rd_n,
    input  logic                 sdata_in,
    output logic                 sdata_out,
    output logic                 sdata_oe,
    output logic                 sys_en,
    output logic                 lcd_on,
    output logic                 bias_third,
    output logic [1:0]           com_sel,
    output logic [DEPTH*NIB-1:0] disp_ram
);
    logic [3:0]     pins_s;
    logic           cs_s, wr_s, rd_s, din_s;
    logic           wr_prev, rd_prev;
    logic           wr_rise, rd_fall, cs_act;
    logic [AW-1:0]  addr;
    logic           we;
    logic [NIB-1:0] wnib;
    logic [NIB-1:0] rnib;
    cfg_t           cfg;

    serlcd_sync #(
        .W       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1110)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({cs_n, wr_n, rd_n, sdata_in}),
        .q_out (pins_s)
    );

    assign {cs_s, wr_s, rd_s, din_s} = pins_s;

    // Previous strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_prev <= 1'b1;
            rd_prev <= 1'b1;
        end else begin
            wr_prev <= wr_s;
            rd_prev <= rd_s;
        end
    end

    assign wr_rise = wr_s & ~wr_prev;
    assign rd_fall = ~rd_s & rd_prev;
    assign cs_act  = ~cs_s;

    serlcd_ctrl #(
        .DEPTH    (DEPTH),
        .NIB      (NIB),
        .ADDR_LEN (ADDR_LEN)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .wr_rise   (wr_rise),
        .rd_fall   (rd_fall),
        .din       (din_s),
        .rd_nibble (rnib),
        .addr      (addr),
        .we        (we),
        .wnib      (wnib),
        .cfg       (cfg),
        .dout      (sdata_out),
        .doe       (sdata_oe)
    );

    serlcd_ram #(
        .DEPTH (DEPTH),
        .NIB   (NIB)
    ) i_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (addr),
        .wdata (wnib),
        .raddr (addr),
        .rdata (rnib),
        .image (disp_ram)
    );

    assign sys_en     = cfg.sys_en;
    assign lcd_on     = cfg.lcd_on;
    assign bias_third = cfg.bias_third;
    assign com_sel    = cfg.com_sel;

    AST_IDLE_RAM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> $stable(disp_ram)); // R2
endmodule

// File: tb/test_serlcd_link.sv
// Directed bench: one task per scenario, each checking its own results.
module test_serlcd_link;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         wr_n = 1'b1;
    logic         rd_n = 1'b1;
    logic         sdata_in = 1'b0;
    logic         sdata_out, sdata_oe, sys_en, lcd_on, bias_third;
    logic [1:0]   com_sel;
    logic [127:0] disp_ram;

    int checks = 0;
    int fails  = 0;
    logic [3:0] exp_ram [32];

    always #5 clk = ~clk;

    serlcd_link i_serlcd_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .wr_n       (wr_n),
        .rd_n       (rd_n),
        .sdata_in   (sdata_in),
        .sdata_out  (sdata_out),
        .sdata_oe   (sdata_oe),
        .sys_en     (sys_en),
        .lcd_on     (lcd_on),
        .bias_third (bias_third),
        .com_sel    (com_sel),
        .disp_ram   (disp_ram)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_start();
        cs_n = 1'b0;
        wait_clk(3);
    endtask

    task automatic cs_stop();
        cs_n = 1'b1;
        wait_clk(4);
    endtask

    task automatic send_bit(input logic b);
        sdata_in = b;
        wr_n = 1'b0;
        wait_clk(3);
        wr_n = 1'b1;
        wait_clk(4);
    endtask

    task automatic send_msb(input logic [8:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_cmd(input logic [7:0] c);
        send_msb({c, 1'b1}, 9);
    endtask

    task automatic send_nib(input logic [3:0] v);
        for (int i = 0; i < 4; i++) send_bit(v[i]);
    endtask

    task automatic read_nib(output logic [3:0] v, output logic oe_all);
        oe_all = 1'b1;
        for (int i = 0; i < 4; i++) begin
            rd_n = 1'b0;
            wait_clk(4);
            v[i] = sdata_out;
            oe_all = oe_all & sdata_oe;
            rd_n = 1'b1;
            wait_clk(3);
        end
    endtask

    task automatic chk_ram(input string tag);
        for (int a = 0; a < 32; a++)
            chk(disp_ram[a*4 +: 4] === exp_ram[a], tag, disp_ram[a*4 +: 4], exp_ram[a]);
    endtask

    task automatic t_reset();
        chk(sys_en === 1'b0, "R1 sys_en", sys_en, 0);
        chk(lcd_on === 1'b0, "R1 lcd_on", lcd_on, 0);
        chk(bias_third === 1'b0, "R1 bias", bias_third, 0);
        chk(com_sel === 2'b00, "R1 com_sel", com_sel, 0);
        chk(disp_ram === '0, "R1 ram", 0, 0);
        chk(sdata_oe === 1'b0, "R1 oe", sdata_oe, 0);
    endtask

    task automatic t_commands();
        cs_start();
        send_msb(9'b100, 3);
        send_cmd(8'b0000_0001);
        chk(sys_en === 1'b1, "R4 sys enable", sys_en, 1);
        send_cmd(8'b0000_0011);
        chk(lcd_on === 1'b1, "R5/R3 lcd on without repeated ID", lcd_on, 1);
        send_cmd(8'b0010_1001);
        chk(com_sel === 2'b10, "R6 four commons", com_sel, 2);
        chk(bias_third === 1'b1, "R6 third bias", bias_third, 1);
        send_cmd(8'b0010_0100);
        chk(com_sel === 2'b01, "R6 three commons", com_sel, 1);
        chk(bias_third === 1'b0, "R6 half bias", bias_third, 0);
        send_cmd(8'b0010_1101);
        chk(com_sel === 2'b01 && bias_third === 1'b0, "R6 ab=11 ignored",
            {com_sel, bias_third}, 3'b010);
        send_cmd(8'b1110_0101);
        chk(lcd_on === 1'b1 && sys_en === 1'b1 && com_sel === 2'b01,
            "R7 unknown code ignored", {sys_en, lcd_on, com_sel}, 4'b1101);
        send_cmd(8'b0000_0010);
        chk(lcd_on === 1'b0, "R5 lcd off", lcd_on, 0);
        send_cmd(8'b0000_0000);
        chk(sys_en === 1'b0, "R4 sys disable", sys_en, 0);
        cs_stop();
    endtask

    task automatic t_abort();
        send_msb(9'b100, 3);
        send_cmd(8'b0000_0011);
        chk(lcd_on === 1'b0, "R2 strobes ignored with cs high", lcd_on, 0);
        cs_start();
        send_msb(9'b100, 3);
        send_msb(9'b00000, 5);
        cs_stop();
        cs_start();
        send_msb(9'b011, 3);
        send_bit(1'b1);
        chk(lcd_on === 1'b0, "R2 aborted command discarded", lcd_on, 0);
        cs_stop();
        chk_ram("R2 ram untouched");
    endtask

    task automatic t_write();
        cs_start();
        send_msb(9'b101, 3);
        send_msb(9'b111110, 6);
        send_nib(4'h5); exp_ram[30] = 4'h5;
        send_nib(4'hA); exp_ram[31] = 4'hA;
        send_nib(4'h3); exp_ram[0]  = 4'h3;
        chk_ram("R8 write with wrap");
        chk(sdata_oe === 1'b0, "R11 no drive while writing", sdata_oe, 0);
        cs_stop();
    endtask

    task automatic t_read();
        logic [3:0] v;
        logic oe_all;
        cs_start();
        send_msb(9'b110, 3);
        send_msb(9'b011110, 6);
        read_nib(v, oe_all);
        chk(v === 4'h5, "R9 read addr 30", v, 5);
        chk(oe_all === 1'b1, "R11 drive during read", oe_all, 1);
        read_nib(v, oe_all);
        chk(v === 4'hA, "R9 read addr 31", v, 10);
        read_nib(v, oe_all);
        chk(v === 4'h3, "R9 read wraps to 0", v, 3);
        cs_stop();
        chk(sdata_oe === 1'b0, "R11 release after cs high", sdata_oe, 0);
    endtask

    task automatic t_rmw();
        logic [3:0] v;
        logic oe_all;
        cs_start();
        send_msb(9'b101, 3);
        send_msb(9'b011111, 6);
        read_nib(v, oe_all);
        chk(v === 4'hA, "R10 rmw read addr 31", v, 10);
        chk(oe_all === 1'b1, "R11 drive in rmw read", oe_all, 1);
        send_nib(4'hC); exp_ram[31] = 4'hC;
        chk(sdata_oe === 1'b0, "R11 release after rmw write", sdata_oe, 0);
        read_nib(v, oe_all);
        chk(v === 4'h3, "R10 rmw read next addr", v, 3);
        send_nib(4'h9); exp_ram[0] = 4'h9;
        chk_ram("R10 rmw writes");
        cs_stop();
    endtask

    task automatic t_unknown_id();
        cs_start();
        send_msb(9'b111, 3);
        send_cmd(8'b0000_0011);
        chk(lcd_on === 1'b0, "R12 unknown id session ignored", lcd_on, 0);
        chk(sdata_oe === 1'b0, "R12 no drive", sdata_oe, 0);
        cs_stop();
        chk_ram("R12 ram untouched");
    endtask

    initial begin
        for (int a = 0; a < 32; a++) exp_ram[a] = 4'h0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_commands();
        t_abort();
        t_write();
        t_read();
        t_rmw();
        t_unknown_id();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule